// File: doc/BRIEF.md
# Power Stage Fault Recovery Sequencer

This block supervises an output power stage that reports overcurrent or overtemperature on an active-low fault line. When the line goes low, the block starts a recovery handshake on an active-low tri-state control output. It pulls the control low for one hold period, which tells the power stage to try to recover, and then lets it return high for one more hold period. At the end of that release period it samples the fault line again. If the fault is still present, the next low period starts at once. If the fault is gone, the episode ends.

While an episode is running, a fault indication output is held high. When the episode ends, the block sends a one-cycle request to the downstream gain stage so that it can fade the audio back in. The hold period is a parameter counted in system clock cycles. The default of 50000 gives 1 ms at a 50 MHz clock. The fault line is asynchronous to the block, so it passes through a flop synchronizer before the sequencer uses it.

Top module: `pwr_fault_recovery`

## Requirements
- R1: During synchronous reset and afterwards, while the fault line stays high, `pstage_tri_n` is 1, `fault_ind` is 0 and `fade_in_req` is 0.
- R2: A low on `pstage_fault_n` sampled at clock edge k drives `pstage_tri_n` to 0 after edge k+SYNC_STAGES, which is three edges with the default of 2 synchronizer stages.
- R3: Each low period of `pstage_tri_n` lasts exactly HOLD_CYCLES clock cycles.
- R4: Each low period is followed by exactly HOLD_CYCLES cycles with `pstage_tri_n` at 1. At the end of that release period, the synchronized fault value decides the next step. With 2 stages, a fault input that is high by the edge two edges before the decision edge ends the episode. A fault input that is still low at that edge starts another low period in the very next cycle.
- R5: While the fault input stays low, the low/high handshake repeats without limit. During this time `fault_ind` stays 1 and no fade request is issued.
- R6: `fault_ind` rises in the same cycle as the first low of `pstage_tri_n`. It stays 1 until the episode ends and is 0 in every idle cycle.
- R7: `fade_in_req` is a single-cycle pulse. It appears in the first idle cycle after an episode, once per episode.
- R8: If the fault clears during a low period, that low period and the following release period still run to full length before the episode ends.
- R9: If a new fault reaches the synchronizer output in the same cycle as the fade pulse, the pulse is still issued. A new low period then begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pstage_fault_n | input | 1 | Fault report from the power stage, active low, asynchronous |
| pstage_tri_n | output | 1 | Recovery control to the power stage, active low |
| fault_ind | output | 1 | High while a recovery episode is in progress |
| fade_in_req | output | 1 | One-cycle request for the gain stage to fade in |

## Verification
The fade-in pulse and the detection of a fresh fault can land in the same cycle. This happens when the idle state, entered at the end of a release period, finds the synchronized fault already low again.

The bench provokes this with a fault input that rises two edges before the decision edge and falls one edge before it. The decision therefore sees no fault, but the next idle cycle does. The bench judges the result by requiring, in consecutive samples, a fade pulse with the indication low, then the control low with the indication high.

A neighbouring case is a release one cycle too late. It must continue the handshake with no fade pulse at all, and the bench checks this as well.

// File: rtl/prf_pkg.sv
package prf_pkg;
   typedef enum logic [1:0] {
      PRF_IDLE    = 2'd0,
      PRF_HOLD    = 2'd1,
      PRF_RELEASE = 2'd2
   } prf_state_e;
endpackage

// File: rtl/prf_sync.sv
module prf_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= RESET_VAL;
               else     chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= RESET_VAL;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/prf_timer.sv
module prf_timer #(
   parameter int HOLD_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic expired
);
   localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                cnt <= '0;
      else if (start)         cnt <= LOAD_VAL;
      else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/prf_fsm.sv
module prf_fsm
   import prf_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       fault_sync_n,
   input  logic       timer_expired,
   output logic       timer_start,
   output prf_state_e state,
   output logic       fade_pulse
);
   prf_state_e nxt;
   logic       fade_set;

   always_comb begin
      nxt         = state;
      timer_start = 1'b0;
      fade_set    = 1'b0;
      unique case (state)
         PRF_IDLE: begin
            if (!fault_sync_n) begin
               nxt         = PRF_HOLD;
               timer_start = 1'b1;
            end
         end
         PRF_HOLD: begin
            if (timer_expired) begin
               nxt         = PRF_RELEASE;
               timer_start = 1'b1;
            end
         end
         PRF_RELEASE: begin
            if (timer_expired) begin
               if (!fault_sync_n) begin
                  nxt         = PRF_HOLD;
                  timer_start = 1'b1;
               end else begin
                  nxt      = PRF_IDLE;
                  fade_set = 1'b1;
               end
            end
         end
         default: nxt = PRF_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= PRF_IDLE;
         fade_pulse <= 1'b0;
      end else begin
         state      <= nxt;
         fade_pulse <= fade_set;
      end
   end
endmodule

// File: rtl/pwr_fault_recovery.sv
module pwr_fault_recovery
   import prf_pkg::*;
#(
   parameter int HOLD_CYCLES = 50000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pstage_fault_n,
   output logic pstage_tri_n,
   output logic fault_ind,
   output logic fade_in_req
);
   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       fault_sync_n;
   logic       timer_start;
   logic       timer_expired;
   prf_state_e state;

   prf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pstage_fault_n),
      .dout (fault_sync_n)
   );

   prf_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (timer_start),
      .expired (timer_expired)
   );

   prf_fsm u_fsm (
      .clk           (clk),
      .rst           (rst),
      .fault_sync_n  (fault_sync_n),
      .timer_expired (timer_expired),
      .timer_start   (timer_start),
      .state         (state),
      .fade_pulse    (fade_in_req)
   );

   assign pstage_tri_n = (state != PRF_HOLD);
   assign fault_ind    = (state != PRF_IDLE);
endmodule

// File: rtl/prf_chk.sv
module prf_chk #(
   parameter int HOLD_CYCLES = 50000
) (
   input logic clk,
   input logic rst,
   input logic pstage_tri_n,
   input logic fault_ind,
   input logic fade_in_req
);
   int low_run;
   int high_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         low_run  <= 0;
         high_run <= 0;
      end else begin
         low_run  <= (!pstage_tri_n) ? low_run + 1 : 0;
         high_run <= (pstage_tri_n && fault_ind) ? high_run + 1 : 0;
      end
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (pstage_tri_n && !fault_ind && !fade_in_req));

   // R3
   low_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pstage_tri_n) |-> (low_run == HOLD_CYCLES));

   // R4
   release_len_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(pstage_tri_n) && $past(fault_ind)) |-> (high_run == HOLD_CYCLES));

   // R6
   tri_needs_ind_chk: assert property (@(posedge clk) disable iff (rst)
      !pstage_tri_n |-> fault_ind);

   // R6
   ind_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(fault_ind) |-> !pstage_tri_n);

   // R7
   fade_single_chk: assert property (@(posedge clk) disable iff (rst)
      fade_in_req |=> !fade_in_req);

   // R7
   fade_after_episode_chk: assert property (@(posedge clk) disable iff (rst)
      fade_in_req |-> ($fell(fault_ind) && pstage_tri_n));

   // R5
   no_fade_in_episode_chk: assert property (@(posedge clk) disable iff (rst)
      fault_ind |-> !fade_in_req);
endmodule

bind pwr_fault_recovery prf_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .pstage_tri_n (pstage_tri_n),
   .fault_ind    (fault_ind),
   .fade_in_req  (fade_in_req)
);

// File: tb/sim_pwr_fault_recovery.sv
module sim_pwr_fault_recovery;
   localparam int HOLD = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pstage_fault_n = 1'b1;
   logic pstage_tri_n;
   logic fault_ind;
   logic fade_in_req;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pwr_fault_recovery #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
      .clk            (clk),
      .rst            (rst),
      .pstage_fault_n (pstage_fault_n),
      .pstage_tri_n   (pstage_tri_n),
      .fault_ind      (fault_ind),
      .fade_in_req    (fade_in_req)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic smp();
      @(negedge clk);
   endtask

   task automatic count_tri(input logic v, output int n);
      n = 0;
      while (pstage_tri_n == v && fault_ind && n < 1000) begin
         n++;
         smp();
      end
   endtask

   // Walk a release phase of HOLD samples, setting the fault input after chosen samples.
   task automatic walk_release(input int set_hi_at, input int set_lo_at, output int n);
      n = 0;
      while (pstage_tri_n && fault_ind && n < 1000) begin
         n++;
         if (n == set_hi_at) pstage_fault_n = 1'b1;
         if (n == set_lo_at) pstage_fault_n = 1'b0;
         smp();
      end
   endtask

   task automatic t_reset();
      smp();
      chk(pstage_tri_n == 1'b1, "R1 tri in reset", pstage_tri_n, 1);
      chk(fault_ind == 1'b0, "R1 ind in reset", fault_ind, 0);
      rst = 1'b0;
      for (int i = 0; i < 6; i++) begin
         smp();
         chk(pstage_tri_n && !fault_ind && !fade_in_req, "R1 idle quiet",
             {pstage_tri_n, fault_ind, fade_in_req}, 3'b100);
      end
   endtask

   task automatic t_single_episode();
      int n;
      pstage_fault_n = 1'b0;
      smp();
      chk(pstage_tri_n == 1'b1, "R2 edge1", pstage_tri_n, 1);
      smp();
      chk(pstage_tri_n == 1'b1, "R2 edge2", pstage_tri_n, 1);
      smp();
      chk(pstage_tri_n == 1'b0, "R2 edge3 low", pstage_tri_n, 0);
      chk(fault_ind == 1'b1, "R6 ind with first low", fault_ind, 1);
      pstage_fault_n = 1'b1;   // R8: clears at once
      count_tri(1'b0, n);
      chk(n == HOLD, "R3 R8 low length", n, HOLD);
      count_tri(1'b1, n);
      chk(n == HOLD, "R4 R8 release length", n, HOLD);
      chk(fade_in_req == 1'b1, "R7 fade pulse", fade_in_req, 1);
      chk(fault_ind == 1'b0, "R6 ind cleared", fault_ind, 0);
      smp();
      chk(fade_in_req == 1'b0, "R7 single pulse", fade_in_req, 0);
      for (int i = 0; i < 4; i++) smp();
      chk(pstage_tri_n && !fault_ind && !fade_in_req, "R7 idle after",
          {pstage_tri_n, fault_ind, fade_in_req}, 3'b100);
   endtask

   task automatic t_repeat();
      int n;
      bit fade_seen = 1'b0;
      pstage_fault_n = 1'b0;
      smp(); smp(); smp();
      for (int c = 0; c < 3; c++) begin
         count_tri(1'b0, n);
         chk(n == HOLD, "R5 repeated low", n, HOLD);
         if (c == 2) break;
         count_tri(1'b1, n);
         chk(n == HOLD, "R5 repeated release", n, HOLD);
         chk(fault_ind == 1'b1 && pstage_tri_n == 1'b0, "R5 restarted",
             fault_ind, 1);
         if (fade_in_req) fade_seen = 1'b1;
      end
      chk(!fade_seen, "R5 no fade while fault", fade_seen, 0);
   endtask

   task automatic t_boundaries();
      int n;
      // in a release phase now, fault still low
      walk_release(7, 0, n);  // too late
      chk(n == HOLD, "R4 late release length", n, HOLD);
      chk(pstage_tri_n == 1'b0 && fault_ind == 1'b1 && !fade_in_req,
          "R4 late clear continues", pstage_tri_n, 0);
      pstage_fault_n = 1'b0;
      count_tri(1'b0, n);
      chk(n == HOLD, "R3 low after late clear", n, HOLD);
      // coincidence: high by sample 6, low again at sample 7
      walk_release(6, 7, n);
      chk(n == HOLD, "R9 release length", n, HOLD);
      chk(fade_in_req == 1'b1 && fault_ind == 1'b0, "R9 fade pulse issued",
          {fade_in_req, fault_ind}, 2'b10);
      smp();
      chk(pstage_tri_n == 1'b0 && fault_ind == 1'b1 && !fade_in_req,
          "R9 new low next cycle", {pstage_tri_n, fault_ind, fade_in_req}, 3'b010);
      count_tri(1'b0, n);
      chk(n == HOLD, "R3 low after coincidence", n, HOLD);
      // release in time: high at sample 6, held
      walk_release(6, 0, n);
      chk(n == HOLD, "R4 release length early", n, HOLD);
      chk(fade_in_req == 1'b1 && fault_ind == 1'b0, "R4 early clear ends",
          {fade_in_req, fault_ind}, 2'b10);
      smp();
      chk(!fade_in_req && pstage_tri_n, "R7 pulse ends", fade_in_req, 0);
   endtask

   initial begin
      t_reset();
      t_single_episode();
      t_repeat();
      t_boundaries();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule